// File: doc/BRIEF.md
# Privileged Trap Return Unit

This block executes the two privileged trap-return operations of a processor core: the return from a machine-level handler and the return from a supervisor-level handler. When a request arrives, it takes the current privilege level, the virtualization flag, the interrupt-enable stack bits, the stored previous-privilege and previous-virtualization bits, the trap-return lock controls and the two saved exception PCs. From these it decides whether the return may proceed.

A legal return produces the unwound interrupt-enable stack, the restored privilege and virtualization state, and the redirect PC, which is the saved PC for that level. An illegal return produces a trap with an exception cause and leaves every state field as it was. When the restored virtualization bit is 1, the unit asks for an exchange of the hypervisor register banks by raising a one-cycle pulse instead of moving any registers itself.

The result is registered. It appears one clock after the request, qualified by a one-cycle valid strobe. The core writes the new fields back into its status registers and redirects fetch.

Top module: `trap_ret_unit`

## Requirements
- R1: A supervisor return (`req_is_mret`=0) issued at privilege U (encoding U=0, S=1, M=3) traps with cause 2 (illegal instruction).
- R2: A machine return (`req_is_mret`=1) issued at any privilege other than M traps with cause 2.
- R3: When `has_compressed` is 0 and either of bits [1:0] of the selected return PC is 1, the return traps with cause 0 (misaligned fetch address). When `has_compressed` is 1, no alignment check is made and the PC is redirected unchanged.
- R4: A supervisor return with `sret_trap_en_i`=1, issued below M, traps with cause 2. The same return issued at M proceeds.
- R5: A supervisor return with `has_hyp`=1, `cur_virt`=1 and `virt_sret_trap_en_i`=1 traps with cause 22 (virtual instruction).
- R6: A legal machine return sets the machine interrupt enable to the old machine previous-enable, sets the previous-enable to 1, sets the previous privilege to U and the new privilege to the old previous privilege, and clears the machine previous-virtualization bit. When `has_hyp`=1 the new virtualization state is the old machine previous-virtualization bit; otherwise `cur_virt` is kept.
- R7: A legal supervisor return sets the supervisor interrupt enable to the old supervisor previous-enable, sets the previous-enable to 1, sets the previous privilege to U, and sets the new privilege to S when the old previous-privilege bit is 1 and to U when it is 0.
- R8: A legal supervisor return with `has_hyp`=1 and `cur_virt`=0 takes its new virtualization state from the old supervisor previous-virtualization bit and clears that bit. When `cur_virt`=1, both are left unchanged. `bank_swap` pulses together with the response exactly when a legal return restores virtualization 1 with `has_hyp`=1.
- R9: On a trap, every state output equals the corresponding input, `redirect_pc` is 0 and `bank_swap` stays 0.
- R10: The response appears with `rsp_valid` high for one cycle, in the cycle after the one in which `req_valid` was high. After reset all outputs are 0.
- R11: When several trap conditions hold at once, the cause is taken from the first of these in order: privilege too low (R1/R2), misaligned PC (R3), supervisor-return lock (R4), virtual supervisor-return lock (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Trap-return request strobe |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Current virtualization state |
| has_compressed | input | 1 | Compressed instructions present (relaxes PC alignment) |
| has_hyp | input | 1 | Hypervisor extension present |
| m_ie_i | input | 1 | Machine interrupt enable |
| s_ie_i | input | 1 | Supervisor interrupt enable |
| m_prev_ie_i | input | 1 | Machine previous interrupt enable |
| s_prev_ie_i | input | 1 | Supervisor previous interrupt enable |
| m_prev_priv_i | input | 2 | Machine previous privilege |
| s_prev_priv_i | input | 1 | Supervisor previous privilege (1 = S) |
| m_prev_virt_i | input | 1 | Machine previous virtualization bit |
| s_prev_virt_i | input | 1 | Supervisor previous virtualization bit (hypervisor status) |
| sret_trap_en_i | input | 1 | Trap supervisor returns issued below M |
| virt_sret_trap_en_i | input | 1 | Trap supervisor returns issued while virtualized |
| m_ret_pc_i | input | XLEN | Saved machine exception PC |
| s_ret_pc_i | input | XLEN | Saved supervisor exception PC |
| rsp_valid | output | 1 | Response strobe |
| rsp_trap | output | 1 | Return was illegal; cause is valid |
| rsp_cause | output | 5 | Exception cause (0, 2 or 22) |
| redirect_pc | output | XLEN | Return target, 0 on trap |
| new_priv | output | 2 | New privilege |
| new_virt | output | 1 | New virtualization state |
| m_ie_o | output | 1 | New machine interrupt enable |
| s_ie_o | output | 1 | New supervisor interrupt enable |
| m_prev_ie_o | output | 1 | New machine previous interrupt enable |
| s_prev_ie_o | output | 1 | New supervisor previous interrupt enable |
| m_prev_priv_o | output | 2 | New machine previous privilege |
| s_prev_priv_o | output | 1 | New supervisor previous privilege |
| m_prev_virt_o | output | 1 | New machine previous virtualization bit |
| s_prev_virt_o | output | 1 | New supervisor previous virtualization bit |
| bank_swap | output | 1 | One-cycle request to exchange hypervisor register banks |

## Verification
On every response, the assertions check the following: the privilege-too-low traps of both return kinds, the misaligned-PC cause when compressed instructions are absent, and the stack unwinding of legal machine and supervisor returns. They also check that a trap never pulses `bank_swap` and redirects to 0, and that a bank-swap pulse occurs only with a response that restores virtualization. The bench scenarios are needed for the rest. They show the ordering among simultaneous trap conditions, the supervisor-return locks, the difference in virtualization handling between a virtualized and a non-virtualized supervisor return, and the exact one-cycle latency. A reference model in the bench also compares the full output word for a mixed set of randomly chosen requests.

// File: rtl/trap_ret_pkg.sv
// Package: shared encodings and the state bundle used by the trap return unit.
// Assumes the privilege encoding U=0, S=1, M=3 (2 is reserved and treated numerically).
package trap_ret_pkg;

    localparam int CAUSE_W = 5;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL        = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT_INSN      = 5'd22;

    // Architectural state touched by a trap return.
    typedef struct packed {
        logic [1:0] priv;
        logic       virt;
        logic       m_ie;
        logic       s_ie;
        logic       m_pie;
        logic       s_pie;
        logic [1:0] m_pp;
        logic       s_pp;
        logic       m_pv;
        logic       s_pv;
    } ret_state_t;

endpackage

// File: rtl/trap_ret_check.sv
// Module: legality checker for trap returns.
// Evaluates the trap conditions in priority order: privilege too low,
// misaligned return PC, supervisor-return lock, virtual supervisor-return lock.
// Purely combinational; assumes the inputs are stable for the request cycle.
module trap_ret_check
    import trap_ret_pkg::*;
(
    input  logic               is_mret,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic               has_c,
    input  logic               has_hyp,
    input  logic               sret_lock,
    input  logic               virt_sret_lock,
    input  logic [1:0]         pc_low,
    output logic               raise,
    output logic [CAUSE_W-1:0] cause
);

    logic misaligned;
    logic low_priv;

    // Alignment is only enforced when compressed instructions are absent.
    assign misaligned = !has_c && (pc_low != 2'b00);

    // Minimum privilege depends on the return kind.
    assign low_priv = is_mret ? (priv != PRIV_M) : (priv < PRIV_S);

    // Priority selection of the first true trap condition.
    always_comb begin
        raise = 1'b0;
        cause = CAUSE_FETCH_MISALIGN;
        if (low_priv) begin
            raise = 1'b1;
            cause = CAUSE_ILLEGAL;
        end else if (misaligned) begin
            raise = 1'b1;
            cause = CAUSE_FETCH_MISALIGN;
        end else if (!is_mret && sret_lock && (priv != PRIV_M)) begin
            raise = 1'b1;
            cause = CAUSE_ILLEGAL;
        end else if (!is_mret && has_hyp && virt && virt_sret_lock) begin
            raise = 1'b1;
            cause = CAUSE_VIRT_INSN;
        end
    end

endmodule

// File: rtl/trap_ret_unwind.sv
// Module: state unwinding for a legal trap return.
// Produces the post-return state and the bank-swap request; assumes the
// caller discards the result when the legality checker raises a trap.
module trap_ret_unwind
    import trap_ret_pkg::*;
(
    input  logic       is_mret,
    input  logic       has_hyp,
    input  ret_state_t cur,
    output ret_state_t nxt,
    output logic       swap
);

    // Compute the unwound interrupt-enable stack and restored modes.
    always_comb begin
        nxt  = cur;
        swap = 1'b0;
        if (is_mret) begin
            nxt.priv  = cur.m_pp;
            nxt.m_ie  = cur.m_pie;
            nxt.m_pie = 1'b1;
            nxt.m_pp  = PRIV_U;
            nxt.m_pv  = 1'b0;
            if (has_hyp) begin
                nxt.virt = cur.m_pv;
                swap     = cur.m_pv;
            end
        end else begin
            nxt.priv  = cur.s_pp ? PRIV_S : PRIV_U;
            nxt.s_ie  = cur.s_pie;
            nxt.s_pie = 1'b1;
            nxt.s_pp  = 1'b0;
            if (has_hyp && !cur.virt) begin
                nxt.virt = cur.s_pv;
                nxt.s_pv = 1'b0;
                swap     = cur.s_pv;
            end
        end
    end

endmodule

// File: rtl/trap_ret_unit.sv
// Module: privileged trap return unit (top).
// Accepts a machine or supervisor return request, checks legality, unwinds
// the status stack and registers the result one cycle after the request.
// Assumes the caller writes the new state back only when rsp_valid is high.
module trap_ret_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_is_mret,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic               has_compressed,
    input  logic               has_hyp,
    input  logic               m_ie_i,
    input  logic               s_ie_i,
    input  logic               m_prev_ie_i,
    input  logic               s_prev_ie_i,
    input  logic [1:0]         m_prev_priv_i,
    input  logic               s_prev_priv_i,
    input  logic               m_prev_virt_i,
    input  logic               s_prev_virt_i,
    input  logic               sret_trap_en_i,
    input  logic               virt_sret_trap_en_i,
    input  logic [XLEN-1:0]    m_ret_pc_i,
    input  logic [XLEN-1:0]    s_ret_pc_i,
    output logic               rsp_valid,
    output logic               rsp_trap,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [1:0]         new_priv,
    output logic               new_virt,
    output logic               m_ie_o,
    output logic               s_ie_o,
    output logic               m_prev_ie_o,
    output logic               s_prev_ie_o,
    output logic [1:0]         m_prev_priv_o,
    output logic               s_prev_priv_o,
    output logic               m_prev_virt_o,
    output logic               s_prev_virt_o,
    output logic               bank_swap
);

    ret_state_t         cur_state;
    ret_state_t         unwound;
    ret_state_t         state_q;
    logic [XLEN-1:0]    ret_pc;
    logic               raise;
    logic [CAUSE_W-1:0] cause;
    logic               swap_req;

    // Gather the incoming state into one bundle.
    assign cur_state = '{priv: cur_priv, virt: cur_virt,
                         m_ie: m_ie_i, s_ie: s_ie_i,
                         m_pie: m_prev_ie_i, s_pie: s_prev_ie_i,
                         m_pp: m_prev_priv_i, s_pp: s_prev_priv_i,
                         m_pv: m_prev_virt_i, s_pv: s_prev_virt_i};

    // Select the saved PC for the requested return level.
    assign ret_pc = req_is_mret ? m_ret_pc_i : s_ret_pc_i;

    trap_ret_check u_check (
        .is_mret        (req_is_mret),
        .priv           (cur_priv),
        .virt           (cur_virt),
        .has_c          (has_compressed),
        .has_hyp        (has_hyp),
        .sret_lock      (sret_trap_en_i),
        .virt_sret_lock (virt_sret_trap_en_i),
        .pc_low         (ret_pc[1:0]),
        .raise          (raise),
        .cause          (cause)
    );

    trap_ret_unwind u_unwind (
        .is_mret (req_is_mret),
        .has_hyp (has_hyp),
        .cur     (cur_state),
        .nxt     (unwound),
        .swap    (swap_req)
    );

    // Register the response; a trap keeps the incoming state unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_trap    <= 1'b0;
            rsp_cause   <= '0;
            redirect_pc <= '0;
            state_q     <= '0;
            bank_swap   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            bank_swap <= req_valid && !raise && swap_req;
            if (req_valid) begin
                rsp_trap    <= raise;
                rsp_cause   <= raise ? cause : '0;
                redirect_pc <= raise ? '0 : ret_pc;
                state_q     <= raise ? cur_state : unwound;
            end
        end
    end

    // Unpack the registered state onto the output ports.
    assign new_priv      = state_q.priv;
    assign new_virt      = state_q.virt;
    assign m_ie_o        = state_q.m_ie;
    assign s_ie_o        = state_q.s_ie;
    assign m_prev_ie_o   = state_q.m_pie;
    assign s_prev_ie_o   = state_q.s_pie;
    assign m_prev_priv_o = state_q.m_pp;
    assign s_prev_priv_o = state_q.s_pp;
    assign m_prev_virt_o = state_q.m_pv;
    assign s_prev_virt_o = state_q.s_pv;

endmodule

// File: rtl/trap_ret_checker.sv
// Module: assertion checker bound to trap_ret_unit.
// Relates each registered response to the request of the previous cycle.
module trap_ret_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_is_mret,
    input logic [1:0]      cur_priv,
    input logic            has_compressed,
    input logic            m_prev_ie_i,
    input logic            s_prev_ie_i,
    input logic [XLEN-1:0] m_ret_pc_i,
    input logic            rsp_valid,
    input logic            rsp_trap,
    input logic [4:0]      rsp_cause,
    input logic [XLEN-1:0] redirect_pc,
    input logic            new_virt,
    input logic            m_ie_o,
    input logic            s_ie_o,
    input logic            m_prev_ie_o,
    input logic            s_prev_ie_o,
    input logic [1:0]      m_prev_priv_o,
    input logic            s_prev_priv_o,
    input logic            m_prev_virt_o,
    input logic            bank_swap
);

    // R2: machine return below M is illegal.
    p_mret_low_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_is_mret) && $past(cur_priv) != 2'd3)
        |-> (rsp_trap && rsp_cause == 5'd2));

    // R1: supervisor return from U is illegal.
    p_sret_low_priv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_is_mret) && $past(cur_priv) == 2'd0)
        |-> (rsp_trap && rsp_cause == 5'd2));

    // R3: misaligned machine return PC without compressed instructions.
    p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_is_mret) && $past(cur_priv) == 2'd3
         && !$past(has_compressed) && $past(m_ret_pc_i[1:0]) != 2'b00)
        |-> (rsp_trap && rsp_cause == 5'd0));

    // R6: machine return unwinding.
    p_mret_unwind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_trap && $past(req_is_mret))
        |-> (m_ie_o == $past(m_prev_ie_i) && m_prev_ie_o
             && m_prev_priv_o == 2'd0 && !m_prev_virt_o));

    // R7: supervisor return unwinding.
    p_sret_unwind_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_trap && !$past(req_is_mret))
        |-> (s_ie_o == $past(s_prev_ie_i) && s_prev_ie_o && !s_prev_priv_o));

    // R9: a trap neither redirects nor requests a bank swap.
    p_trap_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap && rsp_valid |-> (!bank_swap && redirect_pc == '0));

    // R8: a swap pulse only accompanies a response restoring virtualization.
    p_swap_virt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_swap |-> (rsp_valid && new_virt && !rsp_trap));

    // R10: a response follows a request.
    p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

endmodule

bind trap_ret_unit trap_ret_checker #(.XLEN(XLEN)) u_trap_ret_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_is_mret    (req_is_mret),
    .cur_priv       (cur_priv),
    .has_compressed (has_compressed),
    .m_prev_ie_i    (m_prev_ie_i),
    .s_prev_ie_i    (s_prev_ie_i),
    .m_ret_pc_i     (m_ret_pc_i),
    .rsp_valid      (rsp_valid),
    .rsp_trap       (rsp_trap),
    .rsp_cause      (rsp_cause),
    .redirect_pc    (redirect_pc),
    .new_virt       (new_virt),
    .m_ie_o         (m_ie_o),
    .s_ie_o         (s_ie_o),
    .m_prev_ie_o    (m_prev_ie_o),
    .s_prev_ie_o    (s_prev_ie_o),
    .m_prev_priv_o  (m_prev_priv_o),
    .s_prev_priv_o  (s_prev_priv_o),
    .m_prev_virt_o  (m_prev_virt_o),
    .bank_swap      (bank_swap)
);

// File: tb/tb_trap_ret_unit.sv
// Scoreboard bench: the driver computes the expected response from the
// requirements and queues it; the monitor compares each response.
module tb_trap_ret_unit;

    localparam int  XLEN     = 32;
    localparam time CLK_PER  = 10ns;
    localparam int  OUT_W    = 51;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_mret = 1'b0;
    logic [1:0] cur_priv = '0;
    logic cur_virt = 0, has_compressed = 0, has_hyp = 0;
    logic m_ie_i = 0, s_ie_i = 0, m_prev_ie_i = 0, s_prev_ie_i = 0;
    logic [1:0] m_prev_priv_i = '0;
    logic s_prev_priv_i = 0, m_prev_virt_i = 0, s_prev_virt_i = 0;
    logic sret_trap_en_i = 0, virt_sret_trap_en_i = 0;
    logic [XLEN-1:0] m_ret_pc_i = '0, s_ret_pc_i = '0;

    logic rsp_valid, rsp_trap, new_virt, bank_swap;
    logic [4:0] rsp_cause;
    logic [XLEN-1:0] redirect_pc;
    logic [1:0] new_priv, m_prev_priv_o;
    logic m_ie_o, s_ie_o, m_prev_ie_o, s_prev_ie_o, s_prev_priv_o, m_prev_virt_o, s_prev_virt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [OUT_W-1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    trap_ret_unit #(.XLEN(XLEN)) dut (.*);

    function automatic logic [OUT_W-1:0] actual_word();
        return {rsp_trap, rsp_cause, redirect_pc, new_priv, new_virt, m_ie_o, s_ie_o,
                m_prev_ie_o, s_prev_ie_o, m_prev_priv_o, s_prev_priv_o,
                m_prev_virt_o, s_prev_virt_o, bank_swap};
    endfunction

    // Reference model written from the requirements.
    function automatic logic [OUT_W-1:0] model();
        logic trap; logic [4:0] cause; logic [XLEN-1:0] pc; logic mis;
        logic [1:0] pr; logic vt, mie, sie, mpie, spie, spp, mpv, spv, sw; logic [1:0] mpp;
        pc = req_is_mret ? m_ret_pc_i : s_ret_pc_i;
        mis = !has_compressed && pc[1:0] != 2'b00;
        trap = 1; cause = 5'd0;
        if (req_is_mret) begin
            if (cur_priv != 2'd3) cause = 5'd2;
            else if (mis) cause = 5'd0;
            else trap = 0;
        end else begin
            if (cur_priv == 2'd0) cause = 5'd2;
            else if (mis) cause = 5'd0;
            else if (sret_trap_en_i && cur_priv != 2'd3) cause = 5'd2;
            else if (has_hyp && cur_virt && virt_sret_trap_en_i) cause = 5'd22;
            else trap = 0;
        end
        pr = cur_priv; vt = cur_virt; mie = m_ie_i; sie = s_ie_i; mpie = m_prev_ie_i;
        spie = s_prev_ie_i; mpp = m_prev_priv_i; spp = s_prev_priv_i;
        mpv = m_prev_virt_i; spv = s_prev_virt_i; sw = 0;
        if (trap) pc = '0;
        else if (req_is_mret) begin
            pr = m_prev_priv_i; mie = m_prev_ie_i; mpie = 1; mpp = 2'd0; mpv = 0;
            if (has_hyp) begin vt = m_prev_virt_i; sw = m_prev_virt_i; end
            cause = 0;
        end else begin
            pr = s_prev_priv_i ? 2'd1 : 2'd0; sie = s_prev_ie_i; spie = 1; spp = 0;
            if (has_hyp && !cur_virt) begin vt = s_prev_virt_i; spv = 0; sw = s_prev_virt_i; end
            cause = 0;
        end
        return {trap, cause, pc, pr, vt, mie, sie, mpie, spie, mpp, spp, mpv, spv, sw};
    endfunction

    // Driver: issue one request and queue its expected response.
    task automatic issue(input string tag);
        exp_q.push_back(model());
        tag_q.push_back(tag);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Clear the state inputs to a neutral baseline.
    task automatic base(input logic mret, input logic [1:0] pr);
        req_is_mret = mret; cur_priv = pr; cur_virt = 0; has_compressed = 0; has_hyp = 0;
        m_ie_i = 0; s_ie_i = 0; m_prev_ie_i = 0; s_prev_ie_i = 0; m_prev_priv_i = 0;
        s_prev_priv_i = 0; m_prev_virt_i = 0; s_prev_virt_i = 0; sret_trap_en_i = 0;
        virt_sret_trap_en_i = 0; m_ret_pc_i = 32'h8000_1000; s_ret_pc_i = 32'h4000_2000;
    endtask

    // Monitor: compare each response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [OUT_W-1:0] e; string t;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected response: actual=%h expected=none", actual_word());
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (actual_word() !== e) begin
                    fails++;
                    $display("FAIL %s: actual=%h expected=%h", t, actual_word(), e);
                end
            end
        end else if (rst_n && bank_swap) begin
            checks++; fails++;
            $display("FAIL R8 swap without response: actual=1 expected=0");
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({rsp_valid, actual_word()} !== '0) begin
            fails++;
            $display("FAIL R10 reset: actual=%h expected=0", {rsp_valid, actual_word()});
        end

        // R6 machine returns
        base(1, 3); m_prev_ie_i = 1; m_prev_priv_i = 2'd1; issue("R6 mret to S");
        base(1, 3); m_ie_i = 1; m_prev_priv_i = 2'd3; issue("R6 mret to M, ie from 0");
        base(1, 3); has_hyp = 1; m_prev_virt_i = 1; m_prev_priv_i = 2'd1; issue("R6 R8 mret restores virt");
        base(1, 3); m_prev_virt_i = 1; issue("R6 mret no hyp keeps virt");
        // R2
        base(1, 1); issue("R2 mret from S");
        base(1, 0); m_prev_ie_i = 1; issue("R2 R9 mret from U");
        // R3
        base(1, 3); m_ret_pc_i = 32'h8000_1002; issue("R3 mret pc bit1");
        base(1, 3); m_ret_pc_i = 32'h8000_1001; issue("R3 mret pc bit0");
        base(1, 3); has_compressed = 1; m_ret_pc_i = 32'h8000_1002; issue("R3 compressed accepts");
        base(1, 1); m_ret_pc_i = 32'h8000_1002; issue("R11 mret priv before align");
        // R7 / R1
        base(0, 1); s_prev_ie_i = 1; s_prev_priv_i = 1; issue("R7 sret to S");
        base(0, 3); s_ie_i = 1; issue("R7 sret to U");
        base(0, 0); issue("R1 sret from U");
        // R4
        base(0, 1); sret_trap_en_i = 1; issue("R4 sret lock below M");
        base(0, 3); sret_trap_en_i = 1; issue("R4 sret lock at M proceeds");
        // R5
        base(0, 1); has_hyp = 1; cur_virt = 1; virt_sret_trap_en_i = 1; issue("R5 virtual sret lock");
        base(0, 1); has_hyp = 1; cur_virt = 1; s_prev_virt_i = 1; issue("R8 virtualized sret keeps virt");
        base(0, 1); cur_virt = 1; virt_sret_trap_en_i = 1; issue("R5 no hyp ignores lock");
        // R8
        base(0, 3); has_hyp = 1; s_prev_virt_i = 1; issue("R8 sret restores virt 1");
        base(0, 3); has_hyp = 1; issue("R8 sret restores virt 0");
        // R11 ordering
        base(0, 1); s_ret_pc_i = 32'h4000_2002; sret_trap_en_i = 1; issue("R11 align before lock");
        base(0, 0); s_ret_pc_i = 32'h4000_2003; issue("R11 priv before align");
        base(0, 1); sret_trap_en_i = 1; has_hyp = 1; cur_virt = 1; virt_sret_trap_en_i = 1;
        issue("R11 lock before virtual lock");
        // R10 idle gap then mixed requests
        base(0, 1); repeat (2) @(negedge clk);
        for (int i = 0; i < 60; i++) begin
            {req_is_mret, cur_priv, cur_virt, has_compressed, has_hyp} = 6'($urandom);
            {m_ie_i, s_ie_i, m_prev_ie_i, s_prev_ie_i, m_prev_priv_i, s_prev_priv_i} = 7'($urandom);
            {m_prev_virt_i, s_prev_virt_i, sret_trap_en_i, virt_sret_trap_en_i} = 4'($urandom);
            m_ret_pc_i = $urandom; s_ret_pc_i = $urandom;
            issue("R9 R11 mixed");
        end
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing responses: actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule